// File: doc/BRIEF.md
# Linear Congruential Number Generator

This block produces a stream of pseudo-random values by repeatedly applying x(n+1) = (a·x(n) + b) mod m. The multiplier, increment and modulus are elaboration parameters, and the modulus may be any positive integer. Because it need not be a power of two, the block performs a true modular reduction instead of discarding high bits.

A client loads a starting value through a seed port with a one-cycle strobe. It then raises an advance enable on each cycle it wants a new value. The current state is always visible on the output. Whether a given set of parameters reaches the full period of m distinct values is up to the integrator, since a careless choice gives a shorter cycle.

With the defaults (multiplier 15, increment 5, modulus 7), a state of 1 runs through every residue 0 to 6 before it returns to 1.

Top module: `lcg_gen`

## Requirements
- R1: A synchronous active-high reset sets the state to 1 (reduced modulo m) on the clock edge where it is sampled, and reset overrides load and advance.
- R2: With load low and advance high, on the clock edge the state becomes (MULT·x + INCR) mod MODULUS, where x is the state before the edge.
- R3: The output value is always strictly less than MODULUS.
- R4: With load high, on the clock edge the state becomes seed mod MODULUS, whatever the advance input is (load has priority over advance).
- R5: With load and advance both low, the state holds its value across the clock edge.
- R6: With the default parameters and a starting state of 1, successive advances give 6, 4, 2, 0, 5, 3 and then 1 again, a period of 7.
- R7: A seed at or above MODULUS is reduced, not truncated: with the defaults, seeds 7, 200 and 255 load as 0, 4 and 3.
- R8: The intermediate MULT·x + INCR is formed wide enough not to overflow, so the step from the largest state (6 with the defaults) yields 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_i | input | SEED_W | Starting value to load |
| load_i | input | 1 | Load strobe for seed_i |
| step_i | input | 1 | Advance enable |
| value_o | output | VAL_W | Current state |

## Verification
The bench walks the full seven-value orbit from state 1. A design that truncated bits instead of reducing would leave the orbit or emit values of 7 or more. It loads seeds of 7, 200 and 255: a design that sliced the seed would load 7, 0 and 7, which are wrong or out of range. It drives load and advance together, which catches a design that lets advance win. It also crosses the largest state 6, where a narrow intermediate product would wrap and give the wrong successor. Idle cycles and a reset taken in the middle of a run expose a design that drifts without an enable or fails to return to 1.

// File: rtl/lcg_gen.sv
module lcg_gen #(
  parameter int MULT    = 15,
  parameter int INCR    = 5,
  parameter int MODULUS = 7,
  parameter int SEED_W  = 8,
  localparam int VAL_W  = (MODULUS > 2) ? $clog2(MODULUS) : 1,
  localparam int MUL_W  = $clog2(MULT + 1) + 1,
  localparam int INC_W  = $clog2(INCR + 1) + 1,
  localparam int PROD_W = ((VAL_W + MUL_W > INC_W) ? VAL_W + MUL_W : INC_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEED_W-1:0] seed_i,
  input  logic              load_i,
  input  logic              step_i,
  output logic [VAL_W-1:0]  value_o
);

  localparam logic [PROD_W-1:0] MOD_P  = PROD_W'(MODULUS);
  localparam logic [PROD_W-1:0] MULT_P = PROD_W'(MULT);
  localparam logic [PROD_W-1:0] INCR_P = PROD_W'(INCR);
  localparam logic [SEED_W-1:0] MOD_S  = SEED_W'(MODULUS);
  localparam logic [VAL_W-1:0]  START  = VAL_W'(1 % MODULUS);

  logic [PROD_W-1:0] prod;
  logic [VAL_W-1:0]  stepped;
  logic [VAL_W-1:0]  loaded;

  assign prod    = MULT_P * PROD_W'(value_o) + INCR_P;
  assign stepped = VAL_W'(prod % MOD_P);
  assign loaded  = VAL_W'(seed_i % MOD_S);

  always_ff @(posedge clk) begin
    if (rst)         value_o <= START;
    else if (load_i) value_o <= loaded;
    else if (step_i) value_o <= stepped;
  end

endmodule

// File: rtl/lcg_gen_chk.sv
module lcg_gen_chk #(
  parameter int MULT    = 15,
  parameter int INCR    = 5,
  parameter int MODULUS = 7,
  parameter int SEED_W  = 8,
  parameter int VAL_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [SEED_W-1:0] seed_i,
  input logic              load_i,
  input logic              step_i,
  input logic [VAL_W-1:0]  value_o
);

  p_reset_one_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> longint'(value_o) == longint'(1 % MODULUS));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!load_i && step_i) |=>
      longint'(value_o) == (longint'($past(value_o)) * MULT + INCR) % MODULUS);

  p_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    longint'(value_o) < longint'(MODULUS));

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    load_i |=> longint'(value_o) == longint'($past(seed_i)) % MODULUS);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> $stable(value_o));

endmodule

bind lcg_gen lcg_gen_chk #(
  .MULT(MULT), .INCR(INCR), .MODULUS(MODULUS), .SEED_W(SEED_W), .VAL_W(VAL_W)
) u_chk (
  .clk(clk), .rst(rst), .seed_i(seed_i), .load_i(load_i),
  .step_i(step_i), .value_o(value_o)
);

// File: tb/lcg_gen_tb.sv
`timescale 1ns/1ps
module lcg_gen_tb;
  localparam int MULT = 15, INCR = 5, MODULUS = 7, SEED_W = 8, VAL_W = 3;

  logic              clk = 0;
  logic              rst = 1;
  logic [SEED_W-1:0] seed_i = '0;
  logic              load_i = 0;
  logic              step_i = 0;
  logic [VAL_W-1:0]  value_o;

  int    checks = 0, errors = 0;
  int    model = 1;
  int    exp_q[$];
  string tag_q[$];
  bit    done = 0;

  always #5 clk = ~clk;

  lcg_gen #(.MULT(MULT), .INCR(INCR), .MODULUS(MODULUS), .SEED_W(SEED_W)) u_dut (
    .clk(clk), .rst(rst), .seed_i(seed_i), .load_i(load_i),
    .step_i(step_i), .value_o(value_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the value due after the edge
  task automatic op(bit r, bit ld, int sd, bit st, string tag, int force_exp = -1);
    @(negedge clk);
    rst = r; load_i = ld; seed_i = SEED_W'(sd); step_i = st;
    @(posedge clk);
    if (r)       model = 1 % MODULUS;
    else if (ld) model = sd % MODULUS;
    else if (st) model = (model * MULT + INCR) % MODULUS;
    exp_q.push_back(force_exp >= 0 ? force_exp : model);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      check(tag_q.pop_front(), int'(value_o), exp_q.pop_front());
      check("R3", int'(value_o) < MODULUS ? 1 : 0, 1);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1 check("R1", int'(value_o), 1);

    // R6: full orbit from 1 with literal expectations
    begin
      int orbit[7] = '{6, 4, 2, 0, 5, 3, 1};
      for (int i = 0; i < 7; i++) op(0, 0, 0, 1, "R6", orbit[i]);
    end

    // R5: idle cycles hold
    for (int i = 0; i < 3; i++) op(0, 0, 0, 0, "R5");

    // R7: seeds at or above the modulus reduce
    op(0, 1, 7,   0, "R7", 0);
    op(0, 1, 200, 0, "R7", 4);
    op(0, 1, 255, 0, "R7", 3);

    // R4: load wins over advance
    op(0, 1, 2, 1, "R4", 2);
    op(0, 1, 5, 1, "R4", 5);

    // R8: step out of the largest state
    op(0, 1, 6, 0, "R4", 6);
    op(0, 0, 0, 1, "R8", 4);

    // R2: long run against the model, with interleaved holds
    for (int i = 0; i < 4 * MODULUS; i++) op(0, 0, 0, (i % 5) != 3, "R2");

    // R1: reset mid-run, also with load and step high
    op(1, 1, 3, 1, "R1", 1);
    op(0, 0, 0, 1, "R2", 6);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule